// File: doc/BRIEF.md
# Memory ECC error capture unit

This unit sits beside a 64-bit DRAM data path that carries 8 ECC check bits. On every beat the memory side reports an event: the address, the 64-bit data word, the ECC byte, and one strobe for each error kind. The strobes are single-bit corrected, multi-bit uncorrectable, and a parameterised number of other error kinds. The unit turns these strobes into sticky status bits. Single-bit errors pass through a counter first, so they only raise status once a programmable number of them has arrived. The unit also keeps a snapshot of the first failing ECC access and raises one level-sensitive interrupt.

Software reaches the unit through a simple 32-bit word-addressed register port. It can mask detection per error kind, enable the interrupt per kind, clear status by writing ones, and read the snapshot. For test, a set of injection registers can flip chosen bits of the outgoing write data and write ECC. A test routine can use this to provoke known errors on purpose.

Top module: `ecc_err_capture`

## Requirements
- R1: After reset every register reads zero. The interrupt is low, and the outgoing write data and ECC equal their inputs.
- R2: The status register (offset 0x0) uses bit 0 for single-bit, bit 1 for multi-bit and bits 2 upward for the other kinds in strobe order. Writing 1 to a bit clears it and writing 0 leaves it. When an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R3: The mask register (offset 0x1) uses the same bit layout as status. A masked kind sets no status bit. A masked single-bit error is also not counted and is not captured. Writing 0 to the mask enables every kind.
- R4: The interrupt-enable register (offset 0x2) uses the status bit layout. The interrupt output is high exactly when some status bit has its enable bit set.
- R5: The single-bit control register (offset 0x3) holds the threshold in bits 23:16 and reads the current count in bits 7:0, with all other bits reading zero. Each unmasked single-bit event raises the count by one. When the count reaches the threshold, status bit 0 is set and the count returns to 0. A threshold of 0 behaves as 1.
- R6: Any write to the single-bit control register resets the count to 0.
- R7: An unmasked single-bit or multi-bit event updates the snapshot (data, ECC, address) only while status bits 1:0 are both clear. Otherwise the snapshot holds its value.
- R8: The snapshot reads at these offsets: data high word at 0x4, data low word at 0x5, ECC at 0x6 in bits 7:0, address low word at 0x7, address high word at 0x8.
- R9: The injection registers read back what was written. They are the high data mask (0x9), the low data mask (0xA) and control (0xB). Control keeps only bits 8:0.
- R10: While control bit 8 is set, the outgoing data is the input data XOR {high mask, low mask} and the outgoing ECC is the input ECC XOR control bits 7:0. While bit 8 is clear, both pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| ev_valid | input | 1 | Event beat valid |
| ev_addr | input | 64 | Address of the beat |
| ev_data | input | 64 | Data word of the beat |
| ev_ecc | input | 8 | ECC byte of the beat |
| ev_sbe | input | 1 | Single-bit error strobe |
| ev_mbe | input | 1 | Multi-bit error strobe |
| ev_other | input | NUM_OTHER | Other error kind strobes |
| wr_data_in | input | 64 | Outgoing write data before injection |
| wr_ecc_in | input | 8 | Outgoing write ECC before injection |
| wr_data_out | output | 64 | Outgoing write data after injection |
| wr_ecc_out | output | 8 | Outgoing write ECC after injection |
| irq | output | 1 | Error interrupt |

## Verification
The bench sweeps thresholds 0 through 6 and reads status and count after every single-bit event. A counter that is off by one, fires one event early or late, or treats a zero threshold as 256 shows up at a known step. It walks all 16 mask patterns over four error kinds. Each pattern checks status, interrupt and snapshot, which exposes a mask applied to the wrong bit or a snapshot taken from a masked kind. Targeted sequences cover the rest:
- a set and a write-one-clear landing in the same cycle;
- a partial clear that must keep the other bit;
- a snapshot that must not be overwritten by a second error;
- a count reset by rewriting the threshold;
- injection with its enable bit both off and on, which catches masks applied without the enable or to the wrong half-word.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_AW  = 4;
  localparam int REG_DW  = 32;
  localparam int DATA_W  = 64;
  localparam int HALF_W  = DATA_W / 2;
  localparam int ECC_W   = 8;
  localparam int EADDR_W = 64;
  localparam int THR_W   = 8;
  localparam int THR_LSB = 16;
  localparam int INJ_EN_BIT = 8;
  localparam int INJ_CTL_W  = INJ_EN_BIT + 1;

  localparam int KIND_SBE = 0;
  localparam int KIND_MBE = 1;

  localparam logic [REG_AW-1:0] OFS_STATUS  = 4'h0;
  localparam logic [REG_AW-1:0] OFS_MASK    = 4'h1;
  localparam logic [REG_AW-1:0] OFS_IRQEN   = 4'h2;
  localparam logic [REG_AW-1:0] OFS_SBECTL  = 4'h3;
  localparam logic [REG_AW-1:0] OFS_CAP_DHI = 4'h4;
  localparam logic [REG_AW-1:0] OFS_CAP_DLO = 4'h5;
  localparam logic [REG_AW-1:0] OFS_CAP_ECC = 4'h6;
  localparam logic [REG_AW-1:0] OFS_CAP_ALO = 4'h7;
  localparam logic [REG_AW-1:0] OFS_CAP_AHI = 4'h8;
  localparam logic [REG_AW-1:0] OFS_INJ_DHI = 4'h9;
  localparam logic [REG_AW-1:0] OFS_INJ_DLO = 4'hA;
  localparam logic [REG_AW-1:0] OFS_INJ_CTL = 4'hB;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/ecc_sbe_counter.sv
module ecc_sbe_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic [W-1:0] thr,
  output logic         fire,
  output logic [W-1:0] count
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;
  logic [W:0]   cnt_plus;
  logic [W:0]   thr_eff;

  always_comb begin
    thr_eff  = (thr == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, thr};
    cnt_plus = {1'b0, cnt_q} + {{W{1'b0}}, 1'b1};
    fire     = inc && !clr && (cnt_plus >= thr_eff);
    cnt_en   = inc || clr;
    if (clr || fire) cnt_d = '0;
    else             cnt_d = cnt_plus[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/ecc_capture_regs.sv
module ecc_capture_regs #(
  parameter int DW = 64,
  parameter int EW = 8,
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] in_data,
  input  logic [EW-1:0] in_ecc,
  input  logic [AW-1:0] in_addr,
  output logic [DW-1:0] snap_data,
  output logic [EW-1:0] snap_ecc,
  output logic [AW-1:0] snap_addr
);
  logic [DW-1:0] data_q;
  logic [EW-1:0] ecc_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ecc_q  <= '0;
      addr_q <= '0;
    end else if (cap_en) begin
      data_q <= in_data;
      ecc_q  <= in_ecc;
      addr_q <= in_addr;
    end
  end

  assign snap_data = data_q;
  assign snap_ecc  = ecc_q;
  assign snap_addr = addr_q;
endmodule

// File: rtl/ecc_inject_path.sv
module ecc_inject_path #(
  parameter int HW = 32,
  parameter int EW = 8,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_hi,
  input  logic          we_lo,
  input  logic          we_ctl,
  input  logic [HW-1:0] wdata,
  input  logic [2*HW-1:0] data_in,
  input  logic [EW-1:0] ecc_in,
  output logic [2*HW-1:0] data_out,
  output logic [EW-1:0] ecc_out,
  output logic [HW-1:0] mask_hi,
  output logic [HW-1:0] mask_lo,
  output logic [CW-1:0] ctl
);
  logic [HW-1:0] hi_q, lo_q;
  logic [CW-1:0] ctl_q;
  logic          inj_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= '0;
    else if (we_hi) hi_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (we_lo) lo_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (we_ctl) ctl_q <= wdata[CW-1:0];
  end

  always_comb begin
    inj_on = ctl_q[CW-1];
    if (inj_on) begin
      data_out = data_in ^ {hi_q, lo_q};
      ecc_out  = ecc_in ^ ctl_q[EW-1:0];
    end else begin
      data_out = data_in;
      ecc_out  = ecc_in;
    end
  end

  assign mask_hi = hi_q;
  assign mask_lo = lo_q;
  assign ctl     = ctl_q;
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
#(
  parameter int NUM_OTHER = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wen,
  input  logic [3:0]           reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 ev_valid,
  input  logic [63:0]          ev_addr,
  input  logic [63:0]          ev_data,
  input  logic [7:0]           ev_ecc,
  input  logic                 ev_sbe,
  input  logic                 ev_mbe,
  input  logic [NUM_OTHER-1:0] ev_other,
  input  logic [63:0]          wr_data_in,
  input  logic [7:0]           wr_ecc_in,
  output logic [63:0]          wr_data_out,
  output logic [7:0]           wr_ecc_out,
  output logic                 irq
);
  localparam int NK = 2 + NUM_OTHER;

  logic rst_n_s;

  ecc_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  // write decode
  logic wr_status, wr_mask, wr_irqen, wr_sbectl, wr_inj_hi, wr_inj_lo, wr_inj_ctl;
  always_comb begin
    wr_status  = reg_wen && (reg_addr == OFS_STATUS);
    wr_mask    = reg_wen && (reg_addr == OFS_MASK);
    wr_irqen   = reg_wen && (reg_addr == OFS_IRQEN);
    wr_sbectl  = reg_wen && (reg_addr == OFS_SBECTL);
    wr_inj_hi  = reg_wen && (reg_addr == OFS_INJ_DHI);
    wr_inj_lo  = reg_wen && (reg_addr == OFS_INJ_DLO);
    wr_inj_ctl = reg_wen && (reg_addr == OFS_INJ_CTL);
  end

  // configuration registers
  logic [NK-1:0]    mask_q, irqen_q;
  logic [THR_W-1:0] thr_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[NK-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)      irqen_q <= '0;
    else if (wr_irqen) irqen_q <= reg_wdata[NK-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)       thr_q <= '0;
    else if (wr_sbectl) thr_q <= reg_wdata[THR_LSB +: THR_W];
  end

  // event qualification
  logic [NK-1:0] kind_raw, kind_live, set_vec;
  logic          sbe_fire;
  logic [THR_W-1:0] sbe_count;

  always_comb begin
    kind_raw  = ev_valid ? {ev_other, ev_mbe, ev_sbe} : '0;
    kind_live = kind_raw & ~mask_q;
  end

  ecc_sbe_counter #(.W(THR_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n_s),
    .inc   (kind_live[KIND_SBE]),
    .clr   (wr_sbectl),
    .thr   (thr_q),
    .fire  (sbe_fire),
    .count (sbe_count)
  );

  always_comb begin
    set_vec = kind_live;
    set_vec[KIND_SBE] = sbe_fire;
  end

  // sticky status, write-one-to-clear, set wins
  logic [NK-1:0] status_q, status_d;
  logic          status_en;

  always_comb begin
    status_d = status_q;
    if (wr_status) status_d = status_d & ~reg_wdata[NK-1:0];
    status_d  = status_d | set_vec;
    status_en = wr_status || (|set_vec);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)       status_q <= '0;
    else if (status_en) status_q <= status_d;
  end

  // snapshot of first ECC failure
  logic        cap_en;
  logic [63:0] cap_data;
  logic [7:0]  cap_ecc;
  logic [63:0] cap_addr;

  always_comb begin
    cap_en = (kind_live[KIND_SBE] || kind_live[KIND_MBE]) &&
             !(status_q[KIND_SBE] || status_q[KIND_MBE]);
  end

  ecc_capture_regs #(.DW(DATA_W), .EW(ECC_W), .AW(EADDR_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cap_en    (cap_en),
    .in_data   (ev_data),
    .in_ecc    (ev_ecc),
    .in_addr   (ev_addr),
    .snap_data (cap_data),
    .snap_ecc  (cap_ecc),
    .snap_addr (cap_addr)
  );

  // injection
  logic [HALF_W-1:0]    inj_hi, inj_lo;
  logic [INJ_CTL_W-1:0] inj_ctl;

  ecc_inject_path #(.HW(HALF_W), .EW(ECC_W), .CW(INJ_CTL_W)) u_inj (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .we_hi    (wr_inj_hi),
    .we_lo    (wr_inj_lo),
    .we_ctl   (wr_inj_ctl),
    .wdata    (reg_wdata),
    .data_in  (wr_data_in),
    .ecc_in   (wr_ecc_in),
    .data_out (wr_data_out),
    .ecc_out  (wr_ecc_out),
    .mask_hi  (inj_hi),
    .mask_lo  (inj_lo),
    .ctl      (inj_ctl)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_STATUS:  reg_rdata[NK-1:0] = status_q;
      OFS_MASK:    reg_rdata[NK-1:0] = mask_q;
      OFS_IRQEN:   reg_rdata[NK-1:0] = irqen_q;
      OFS_SBECTL: begin
        reg_rdata[THR_LSB +: THR_W] = thr_q;
        reg_rdata[THR_W-1:0]        = sbe_count;
      end
      OFS_CAP_DHI: reg_rdata = cap_data[DATA_W-1:HALF_W];
      OFS_CAP_DLO: reg_rdata = cap_data[HALF_W-1:0];
      OFS_CAP_ECC: reg_rdata[ECC_W-1:0] = cap_ecc;
      OFS_CAP_ALO: reg_rdata = cap_addr[31:0];
      OFS_CAP_AHI: reg_rdata = cap_addr[63:32];
      OFS_INJ_DHI: reg_rdata = inj_hi;
      OFS_INJ_DLO: reg_rdata = inj_lo;
      OFS_INJ_CTL: reg_rdata[INJ_CTL_W-1:0] = inj_ctl;
      default:     reg_rdata = '0;
    endcase
  end

  assign irq = |(status_q & irqen_q);
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk #(
  parameter int NK = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wen,
  input logic [3:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          ev_valid,
  input logic          ev_mbe,
  input logic [NK-1:0] status_q,
  input logic [NK-1:0] mask_q,
  input logic [7:0]    thr_q,
  input logic [7:0]    sbe_count,
  input logic [63:0]   cap_data,
  input logic [7:0]    cap_ecc,
  input logic [8:0]    inj_ctl,
  input logic [63:0]   wr_data_in,
  input logic [63:0]   wr_data_out,
  input logic          irq
);
  logic mbe_live;
  logic [8:0] thr_eff;
  always_comb begin
    mbe_live = ev_valid && ev_mbe && !mask_q[1];
    thr_eff  = (thr_q == 8'd0) ? 9'd1 : {1'b0, thr_q};
  end

  assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mbe_live |=> status_q[1]);

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == 4'h0 && reg_wdata[1] && !mbe_live) |=> !status_q[1]);

  assert_masked_no_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_q[1] && !mbe_live) |=> !status_q[1]);

  assert_irq_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_q != '0));

  assert_cnt_below_thr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, sbe_count} < thr_eff);

  assert_snapshot_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|status_q[1:0]) |=> ($stable(cap_data) && $stable(cap_ecc)));

  assert_inject_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_ctl[8] |-> (wr_data_out == wr_data_in));
endmodule

bind ecc_err_capture ecc_err_capture_chk #(.NK(NK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .reg_wen     (reg_wen),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .ev_valid    (ev_valid),
  .ev_mbe      (ev_mbe),
  .status_q    (status_q),
  .mask_q      (mask_q),
  .thr_q       (thr_q),
  .sbe_count   (sbe_count),
  .cap_data    (cap_data),
  .cap_ecc     (cap_ecc),
  .inj_ctl     (inj_ctl),
  .wr_data_in  (wr_data_in),
  .wr_data_out (wr_data_out),
  .irq         (irq)
);

// File: tb/tb_ecc_err_capture.sv
module tb_ecc_err_capture;
  logic        clk;
  logic        rst_n;
  logic        reg_wen;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        ev_valid;
  logic [63:0] ev_addr;
  logic [63:0] ev_data;
  logic [7:0]  ev_ecc;
  logic        ev_sbe;
  logic        ev_mbe;
  logic [1:0]  ev_other;
  logic [63:0] wr_data_in;
  logic [7:0]  wr_ecc_in;
  logic [63:0] wr_data_out;
  logic [7:0]  wr_ecc_out;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  ecc_err_capture #(.NUM_OTHER(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ev_valid(ev_valid), .ev_addr(ev_addr), .ev_data(ev_data), .ev_ecc(ev_ecc),
    .ev_sbe(ev_sbe), .ev_mbe(ev_mbe), .ev_other(ev_other),
    .wr_data_in(wr_data_in), .wr_ecc_in(wr_ecc_in),
    .wr_data_out(wr_data_out), .wr_ecc_out(wr_ecc_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic set_ev(input logic [3:0] k, input logic [63:0] d,
                        input logic [7:0] e, input logic [63:0] a);
    ev_valid = 1'b1; ev_sbe = k[0]; ev_mbe = k[1]; ev_other = k[3:2];
    ev_data = d; ev_ecc = e; ev_addr = a;
  endtask

  task automatic clr_ev();
    ev_valid = 1'b0; ev_sbe = 1'b0; ev_mbe = 1'b0; ev_other = 2'b00;
  endtask

  task automatic pulse(input logic [3:0] k, input logic [63:0] d,
                       input logic [7:0] e, input logic [63:0] a);
    @(negedge clk);
    set_ev(k, d, e, a);
    @(negedge clk);
    clr_ev();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    logic [31:0] r;
    logic [63:0] cd, ca;
    logic [7:0]  ce;
    reg_wen = 0; reg_addr = 0; reg_wdata = 0;
    clr_ev(); ev_data = 0; ev_ecc = 0; ev_addr = 0;
    wr_data_in = 64'h0123_4567_89AB_CDEF; wr_ecc_in = 8'h3C;
    rst_n = 0;
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (5) @(posedge clk);

    // R1: reset values
    for (int a = 0; a < 12; a++) begin
      rd(a[3:0], r);
      chk("R1 reg reset", {32'h0, r}, 64'h0);
    end
    chk("R1 irq reset", {63'h0, irq}, 64'h0);
    chk("R1 data pass", wr_data_out, wr_data_in);
    chk("R1 ecc pass", {56'h0, wr_ecc_out}, {56'h0, wr_ecc_in});

    // R5: threshold sweep, threshold 0 behaves as 1
    for (int t = 0; t <= 6; t++) begin
      int eff;
      eff = (t == 0) ? 1 : t;
      wr(4'h3, t << 16);
      wr(4'h0, 32'hFFFF_FFFF);
      for (int n = 1; n <= eff; n++) begin
        pulse(4'b0001, 64'h0, 8'h0, 64'h0);
        rd(4'h0, r);
        chk("R5 sbe status step", {63'h0, r[0]}, {63'h0, (n == eff)});
        rd(4'h3, r);
        chk("R5 count readback", {32'h0, r}, {32'h0, 32'(t << 16) | 32'(n % eff)});
      end
    end

    // R6: rewrite threshold resets count
    wr(4'h3, 32'h0004_0000);
    pulse(4'b0001, 64'h0, 8'h0, 64'h0);
    pulse(4'b0001, 64'h0, 8'h0, 64'h0);
    rd(4'h3, r);
    chk("R6 count before rewrite", {32'h0, r}, 64'h0004_0002);
    wr(4'h3, 32'h0004_0000);
    rd(4'h3, r);
    chk("R6 count after rewrite", {32'h0, r}, 64'h0004_0000);

    // R2 R3 R4 R7 R8: exhaustive mask sweep
    cd = 64'h0; ce = 8'h0; ca = 64'h0;
    rd(4'h4, r); cd[63:32] = r;
    rd(4'h5, r); cd[31:0] = r;
    rd(4'h6, r); ce = r[7:0];
    rd(4'h7, r); ca[31:0] = r;
    rd(4'h8, r); ca[63:32] = r;
    wr(4'h3, 32'h0001_0000);
    wr(4'h2, 32'h0000_000F);
    for (int m = 0; m < 16; m++) begin
      wr(4'h1, m);
      wr(4'h0, 32'hFFFF_FFFF);
      for (int k = 0; k < 4; k++) begin
        logic [31:0] hi;
        logic [63:0] d, a;
        logic [7:0] e;
        hi = 32'hC0DE_0000 | 32'(m << 4) | 32'(k);
        d  = {hi, ~hi};
        e  = {m[3:0], k[3:0]};
        a  = {32'h0000_00F0 + 32'(m), 32'h1000_0000 + 32'(m * 16 + k)};
        pulse(4'(1 << k), d, e, a);
        if ((k == 0 && !m[0]) || (k == 1 && !m[1] && m[0])) begin
          cd = d; ce = e; ca = a;
        end
      end
      rd(4'h0, r);
      chk("R3 status vs mask", {32'h0, r}, {60'h0, ~m[3:0]});
      chk("R4 irq all enabled", {63'h0, irq}, {63'h0, (m != 15)});
      rd(4'h3, r);
      chk("R3 count untouched", {32'h0, r}, 64'h0001_0000);
      rd(4'h4, r); chk("R8 snap data hi", {32'h0, r}, {32'h0, cd[63:32]});
      rd(4'h5, r); chk("R7 snap data lo", {32'h0, r}, {32'h0, cd[31:0]});
      rd(4'h6, r); chk("R8 snap ecc", {32'h0, r}, {56'h0, ce});
      rd(4'h7, r); chk("R8 snap addr lo", {32'h0, r}, {32'h0, ca[31:0]});
      rd(4'h8, r); chk("R8 snap addr hi", {32'h0, r}, {32'h0, ca[63:32]});
    end
    wr(4'h1, 32'h0);
    rd(4'h1, r);
    chk("R3 mask zero", {32'h0, r}, 64'h0);

    // R4: partial enables
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h2, 32'h1);
    pulse(4'b0010, 64'h11, 8'h11, 64'h11);
    chk("R4 mbe not enabled", {63'h0, irq}, 64'h0);
    wr(4'h2, 32'h2);
    #1;
    chk("R4 mbe enabled", {63'h0, irq}, 64'h1);

    // R7: snapshot holds while status set
    pulse(4'b0010, 64'h22, 8'h22, 64'h22);
    rd(4'h5, r);
    chk("R7 snapshot held", {32'h0, r}, 64'h11);

    // R2: set wins over same-cycle clear, partial clear keeps other bit
    wr(4'h0, 32'hFFFF_FFFF);
    @(negedge clk);
    set_ev(4'b0010, 64'h33, 8'h33, 64'h33);
    reg_wen = 1'b1; reg_addr = 4'h0; reg_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    clr_ev(); reg_wen = 1'b0;
    rd(4'h0, r);
    chk("R2 set wins", {32'h0, r}, 64'h2);
    pulse(4'b0001, 64'h44, 8'h44, 64'h44);
    wr(4'h0, 32'h1);
    rd(4'h0, r);
    chk("R2 partial clear", {32'h0, r}, 64'h2);

    // R7: below-threshold singles refresh the snapshot while status clear
    wr(4'h0, 32'hFFFF_FFFF);
    wr(4'h3, 32'h0003_0000);
    pulse(4'b0001, 64'h55, 8'h55, 64'h55);
    pulse(4'b0001, 64'h66, 8'h66, 64'h66);
    rd(4'h5, r);
    chk("R7 snapshot while clear", {32'h0, r}, 64'h66);

    // R9 R10: injection
    wr(4'h9, 32'hFFFF_0000);
    wr(4'hA, 32'h0000_00F1);
    wr(4'hB, 32'hFFFF_FE5A);
    rd(4'h9, r); chk("R9 inj hi readback", {32'h0, r}, 64'hFFFF_0000);
    rd(4'hA, r); chk("R9 inj lo readback", {32'h0, r}, 64'h0000_00F1);
    rd(4'hB, r); chk("R9 inj ctl readback", {32'h0, r}, 64'h05A);
    for (int p = 0; p < 4; p++) begin
      wr_data_in = {32'(p * 32'h1357_9BDF), 32'(~(p * 32'h0246_8ACE))};
      wr_ecc_in  = 8'(p * 37);
      #1;
      chk("R10 inject off data", wr_data_out, wr_data_in);
      chk("R10 inject off ecc", {56'h0, wr_ecc_out}, {56'h0, wr_ecc_in});
    end
    wr(4'hB, 32'h0000_01A5);
    for (int p = 0; p < 4; p++) begin
      wr_data_in = {32'(p * 32'h1357_9BDF), 32'(~(p * 32'h0246_8ACE))};
      wr_ecc_in  = 8'(p * 37);
      #1;
      chk("R10 inject on data", wr_data_out, wr_data_in ^ 64'hFFFF_0000_0000_00F1);
      chk("R10 inject on ecc", {56'h0, wr_ecc_out}, {56'h0, wr_ecc_in ^ 8'hA5});
    end

    done = 1;
    report();
  end
endmodule